// File: doc/BRIEF.md
# Triggered Compare Pulse Generator

This block drives two digital outputs from a 16-bit down-counter that reloads itself, together with three compare values. It has two modes. In triggered mode the counter waits for a start edge on an external trigger line and then produces a one-shot pulse that repeats. The trigger is synchronised, passed through a four-sample glitch filter and then through a delay line with selectable length. In PWM mode the counter runs free as soon as it is enabled. The reload value sets the period, and the compare values place the edges of both outputs.

In triggered mode, two fault inputs, each with its own enable, can force the block into a held stop. While stopped, both outputs are driven low. The stop lasts until software pulses a clear input. A per-output invert bit flips the polarity of each output, except while the stop is held.

The control is a single state machine with these states:
- `ST_IDLE`: entered when `en` is low.
- `ST_ARMED`: triggered mode, waiting for a trigger.
- `ST_RUN`: triggered mode, counting.
- `ST_PWM`: free-running PWM.
- `ST_HALT`: forced stop.

Its transitions are:
- IDLE to ARMED or PWM when enabled, depending on the mode.
- ARMED to RUN on a filtered trigger edge.
- ARMED or RUN to HALT on an enabled fault.
- HALT to IDLE on a stop clear.
- Any state except HALT to IDLE when `en` drops.

Top module: `trig_pulse_gen`

## Requirements
- R1: After reset, `out1`, `out2`, `count` and `stopped` are all 0, with both invert bits at 0.
- R2: A trigger level is accepted only after the synchronised input has held the new level for 4 consecutive clocks. A high pulse lasting 3 clocks starts nothing.
- R3: `dly_sel` values 0, 1, 2 and 3 add 0, 2, 4 and 8 clocks of delay. With `en` set in triggered mode, `out1` rises at the (7 + delay)th rising clock edge after `trig_in` goes high.
- R4: In triggered mode, a trigger edge loads `count` with `reload` and drives `out1` high. After that, `count` decrements by one per clock. When `count` is 0, it reloads on the next clock and `out1` is set high again, so the period is `reload`+1 clocks. In the clock after `count` equals `cmp1`, `out1` goes low. When both events occur in the same cycle, the set wins.
- R5: In PWM mode (`pwm_mode`=1), counting starts when `en` is set. `out1` then has a period of `reload`+1 clocks and is high for `reload`-`cmp1`+1 clocks of each period, for 0 < `cmp1` <= `reload`.
- R6: `out2` goes high in the clock after `count` equals `cmp2` and low in the clock after `count` equals `cmp3`; `cmp3` wins if both match. It is therefore high for `cmp2`-`cmp3` clocks per period when `cmp3` < `cmp2` <= `reload`.
- R7: When `inv1` or `inv2` is 1, the matching output is inverted. This includes the idle level.
- R8: In triggered mode, a fault input that is high while its enable bit is set forces `stopped` to 1 at the third rising edge after the input rises. From that edge on, both outputs are low whatever the invert bits are, and `count` freezes. A fault whose enable bit is 0 has no effect.
- R9: While `stopped` is 1, triggers are ignored. A one-clock pulse on `stop_clr` returns the block to idle, and if `en` is still set it re-arms.
- R10: In PWM mode, the trigger and fault inputs have no effect.
- R11: Dropping `en` returns the block to idle within one clock: `count` becomes 0 and the outputs go to their inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Count enable |
| pwm_mode | input | 1 | 1 selects PWM mode, 0 selects triggered mode |
| dly_sel | input | 2 | Trigger delay select (0/2/4/8 clocks) |
| inv1 | input | 1 | Invert output 1 |
| inv2 | input | 1 | Invert output 2 |
| reload | input | 16 | Counter reload value |
| cmp1 | input | 16 | Output 1 clear compare |
| cmp2 | input | 16 | Output 2 set compare |
| cmp3 | input | 16 | Output 2 clear compare |
| trig_in | input | 1 | Asynchronous start trigger |
| fault1_in | input | 1 | Asynchronous fault input 1 |
| fault2_in | input | 1 | Asynchronous fault input 2 |
| fault1_en | input | 1 | Enable for fault input 1 |
| fault2_en | input | 1 | Enable for fault input 2 |
| stop_clr | input | 1 | Pulse that clears a forced stop |
| out1 | output | 1 | Pulse output 1 |
| out2 | output | 1 | Pulse output 2 |
| count | output | 16 | Current counter value |
| stopped | output | 1 | Forced stop held |

## Verification
If the counter skips or repeats a value, the error shows within one period. The high time and period of each output, measured over a whole number of periods, would move away from the expected `reload`/compare arithmetic.

A wrong filter or delay length shifts the rise of `out1` by a fixed number of clocks after the trigger, so it is caught the first time the block is armed. A stop state that fails to hold, or that drops the forced-low, lets `count` move or an output toggle during the next trigger, which the ports show within a few tens of clocks.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_RUN   = 3'd2,
        ST_PWM   = 3'd3,
        ST_HALT  = 3'd4
    } tpg_state_t;

    localparam int FILT_SAMPLES = 4;
    localparam int DLY_LONGEST  = 8;

endpackage

// File: rtl/tpg_sync.sv
module tpg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[i] <= '0;
                    else        stage[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stage[i] <= '0;
                    else        stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/tpg_trig_cond.sv
module tpg_trig_cond #(
    parameter int FILT_N  = tpg_pkg::FILT_SAMPLES,
    parameter int DLY_MAX = tpg_pkg::DLY_LONGEST
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_s,
    input  logic [1:0] dly_sel,
    output logic       trig_evt
);
    localparam int RUN_W = (FILT_N > 2) ? $clog2(FILT_N) : 1;
    localparam int TAP_A = DLY_MAX / 4;
    localparam int TAP_B = DLY_MAX / 2;

    logic             filt;
    logic [RUN_W-1:0] run;
    logic [DLY_MAX:1] dline;
    logic             tap;
    logic             tap_q;

    // glitch filter: level taken after FILT_N equal samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt <= 1'b0;
            run  <= '0;
        end else if (trig_s != filt) begin
            if (run == RUN_W'(FILT_N - 1)) begin
                filt <= trig_s;
                run  <= '0;
            end else begin
                run <= run + RUN_W'(1);
            end
        end else begin
            run <= '0;
        end
    end

    generate
        if (DLY_MAX > 1) begin : g_line
            always_ff @(posedge clk) begin
                if (!rst_n) dline <= '0;
                else        dline <= {dline[DLY_MAX-1:1], filt};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) dline <= '0;
                else        dline <= filt;
            end
        end
    endgenerate

    always_comb begin
        unique case (dly_sel)
            2'd0:    tap = filt;
            2'd1:    tap = dline[TAP_A];
            2'd2:    tap = dline[TAP_B];
            default: tap = dline[DLY_MAX];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tap_q <= 1'b0;
        else        tap_q <= tap;
    end

    assign trig_evt = tap & ~tap_q;
endmodule

// File: rtl/tpg_core.sv
module tpg_core
    import tpg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pwm_mode,
    input  logic             inv1,
    input  logic             inv2,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] cmp1,
    input  logic [CNT_W-1:0] cmp2,
    input  logic [CNT_W-1:0] cmp3,
    input  logic             trig_evt,
    input  logic             fault_hit,
    input  logic             stop_clr,
    output logic             out1,
    output logic             out2,
    output logic [CNT_W-1:0] count,
    output logic             stopped,
    output logic             run_act
);
    tpg_state_t st, nxt;
    logic [CNT_W-1:0] cnt;
    logic raw1, raw2;
    logic start_now, stepping;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (en) nxt = pwm_mode ? ST_PWM : ST_ARMED;
            ST_ARMED: begin
                if (!en)            nxt = ST_IDLE;
                else if (fault_hit) nxt = ST_HALT;
                else if (trig_evt)  nxt = ST_RUN;
            end
            ST_RUN: begin
                if (!en)            nxt = ST_IDLE;
                else if (fault_hit) nxt = ST_HALT;
            end
            ST_PWM:   if (!en) nxt = ST_IDLE;
            ST_HALT:  if (stop_clr) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    assign start_now = ((st == ST_IDLE)  && (nxt == ST_PWM)) ||
                       ((st == ST_ARMED) && (nxt == ST_RUN));
    assign stepping  = ((st == ST_RUN) && (nxt == ST_RUN)) ||
                       ((st == ST_PWM) && (nxt == ST_PWM));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            raw1 <= 1'b0;
            raw2 <= 1'b0;
        end else if (start_now) begin
            cnt  <= reload;
            raw1 <= 1'b1;
            raw2 <= 1'b0;
        end else if (stepping) begin
            cnt <= (cnt == '0) ? reload : cnt - CNT_W'(1);
            if (cnt == '0)        raw1 <= 1'b1;
            else if (cnt == cmp1) raw1 <= 1'b0;
            if (cnt == cmp3)      raw2 <= 1'b0;
            else if (cnt == cmp2) raw2 <= 1'b1;
        end else if (nxt == ST_HALT) begin
            raw1 <= 1'b0;
            raw2 <= 1'b0;
        end else if (nxt == ST_IDLE || nxt == ST_ARMED) begin
            cnt  <= '0;
            raw1 <= 1'b0;
            raw2 <= 1'b0;
        end
    end

    always_comb begin
        stopped = (st == ST_HALT);
        run_act = (st == ST_RUN) || (st == ST_PWM);
        count   = cnt;
        out1    = stopped ? 1'b0 : (raw1 ^ inv1);
        out2    = stopped ? 1'b0 : (raw2 ^ inv2);
    end
endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pwm_mode,
    input  logic [1:0]       dly_sel,
    input  logic             inv1,
    input  logic             inv2,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] cmp1,
    input  logic [CNT_W-1:0] cmp2,
    input  logic [CNT_W-1:0] cmp3,
    input  logic             trig_in,
    input  logic             fault1_in,
    input  logic             fault2_in,
    input  logic             fault1_en,
    input  logic             fault2_en,
    input  logic             stop_clr,
    output logic             out1,
    output logic             out2,
    output logic [CNT_W-1:0] count,
    output logic             stopped
);
    localparam int N_ASYNC = 3;

    logic [N_ASYNC-1:0] async_s;
    logic trig_evt;
    logic fault_hit;
    logic run_act;

    tpg_sync #(.W(N_ASYNC), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({fault2_in, fault1_in, trig_in}),
        .q     (async_s)
    );

    tpg_trig_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_s   (async_s[0]),
        .dly_sel  (dly_sel),
        .trig_evt (trig_evt)
    );

    assign fault_hit = (fault1_en & async_s[1]) | (fault2_en & async_s[2]);

    tpg_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .pwm_mode  (pwm_mode),
        .inv1      (inv1),
        .inv2      (inv2),
        .reload    (reload),
        .cmp1      (cmp1),
        .cmp2      (cmp2),
        .cmp3      (cmp3),
        .trig_evt  (trig_evt),
        .fault_hit (fault_hit),
        .stop_clr  (stop_clr),
        .out1      (out1),
        .out2      (out2),
        .count     (count),
        .stopped   (stopped),
        .run_act   (run_act)
    );
endmodule

// File: rtl/trig_pulse_gen_chk.sv
module trig_pulse_gen_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_clr,
    input logic [CNT_W-1:0] reload,
    input logic             out1,
    input logic             out2,
    input logic [CNT_W-1:0] count,
    input logic             stopped,
    input logic             run_act
);
    AST_HALT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> (!out1 && !out2)); // R8

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !stop_clr) |=> stopped); // R9

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_act && count != '0) |=> (!run_act || count == $past(count) - CNT_W'(1))); // R4

    AST_UNDERFLOW_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_act && count == '0) |=> (!run_act || count == $past(reload))); // R4

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && $past(stopped)) |-> $stable(count)); // R8
endmodule

bind trig_pulse_gen trig_pulse_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_clr (stop_clr),
    .reload   (reload),
    .out1     (out1),
    .out2     (out2),
    .count    (count),
    .stopped  (stopped),
    .run_act  (run_act)
);

// File: tb/tb_trig_pulse_gen.sv
`timescale 1ns/1ps
module tb_trig_pulse_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 0, pwm_mode = 0, inv1 = 0, inv2 = 0;
    logic [1:0] dly_sel = 2'd0;
    logic [15:0] reload = 16'd20, cmp1 = 16'd15, cmp2 = 16'd0, cmp3 = 16'd0;
    logic trig_in = 0, fault1_in = 0, fault2_in = 0, fault1_en = 0, fault2_en = 0, stop_clr = 0;
    logic out1, out2, stopped;
    logic [15:0] count;
    int n_tests = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    trig_pulse_gen dut (
        .clk(clk), .rst_n(rst_n), .en(en), .pwm_mode(pwm_mode), .dly_sel(dly_sel),
        .inv1(inv1), .inv2(inv2), .reload(reload), .cmp1(cmp1), .cmp2(cmp2), .cmp3(cmp3),
        .trig_in(trig_in), .fault1_in(fault1_in), .fault2_in(fault2_in),
        .fault1_en(fault1_en), .fault2_en(fault2_en), .stop_clr(stop_clr),
        .out1(out1), .out2(out2), .count(count), .stopped(stopped)
    );

    task automatic check(input string rq, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic idle_all();
        @(negedge clk);
        en = 0; trig_in = 0; fault1_in = 0; fault2_in = 0;
        fault1_en = 0; fault2_en = 0; stop_clr = 0; inv1 = 0; inv2 = 0;
        repeat (25) @(negedge clk);
    endtask

    // arm triggered mode and fire a trigger; returns edges until out1 changes
    task automatic fire(output int n);
        @(negedge clk);
        pwm_mode = 0; en = 1;
        repeat (20) @(negedge clk);
        trig_in = 1;
        n = 0;
        while (out1 == inv1 && n < 60) begin
            @(posedge clk); n++; #1;
        end
    endtask

    task automatic t_reset();
        check("R1", "out1", out1, 0);
        check("R1", "out2", out2, 0);
        check("R1", "count", count, 0);
        check("R1", "stopped", stopped, 0);
    endtask

    task automatic t_delay(input logic [1:0] ds, input int extra);
        int n;
        idle_all();
        dly_sel = ds; reload = 16'd20; cmp1 = 16'd15;
        fire(n);
        check("R3", "trigger latency", n, 7 + extra);
        idle_all();
        dly_sel = 2'd0;
    endtask

    task automatic t_glitch();
        idle_all();
        reload = 16'd20; cmp1 = 16'd15;
        @(negedge clk); pwm_mode = 0; en = 1;
        repeat (20) @(negedge clk);
        trig_in = 1; repeat (3) @(negedge clk); trig_in = 0;
        repeat (30) @(negedge clk);
        check("R2", "count after 3-clock glitch", count, 0);
        check("R2", "out1 after 3-clock glitch", out1, 0);
        trig_in = 1; repeat (4) @(negedge clk); trig_in = 0;
        repeat (12) @(negedge clk);
        check("R2", "started after 4-clock pulse", int'(count != 0), 1);
        idle_all();
    endtask

    task automatic t_trig_run();
        int n, h, p;
        idle_all();
        reload = 16'd20; cmp1 = 16'd15; cmp2 = 16'd0; cmp3 = 16'd0;
        fire(n);
        check("R4", "count at trigger", count, 20);
        h = 0;
        while (out1 && h < 60) begin @(posedge clk); h++; #1; end
        check("R4", "high clocks", h, 6);
        p = h;
        while (!out1 && p < 80) begin @(posedge clk); p++; #1; end
        check("R4", "period on underflow", p, 21);
        idle_all();
    endtask

    task automatic measure(input int win, output int hi1, output int hi2, output int rises);
        logic prev;
        hi1 = 0; hi2 = 0; rises = 0;
        @(negedge clk); prev = out1;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (out1) hi1++;
            if (out2) hi2++;
            if (out1 && !prev) rises++;
            prev = out1;
        end
    endtask

    task automatic t_pwm(input logic i1, input logic noisy);
        int h1, h2, r;
        idle_all();
        pwm_mode = 1; reload = 16'd9; cmp1 = 16'd4; cmp2 = 16'd7; cmp3 = 16'd2;
        inv1 = i1; inv2 = 0;
        if (noisy) begin fault1_en = 1; fault2_en = 1; end
        @(negedge clk); en = 1;
        if (noisy) begin fault1_in = 1; fault2_in = 1; trig_in = 1; end
        repeat (25) @(negedge clk);
        if (noisy) trig_in = 0;
        measure(30, h1, h2, r);
        if (!i1) begin
            check(noisy ? "R10" : "R5", "out1 high clocks", h1, 18);
            check(noisy ? "R10" : "R5", "out1 periods", r, 3);
            check(noisy ? "R10" : "R6", "out2 high clocks", h2, 15);
        end else begin
            check("R7", "inverted out1 high clocks", h1, 12);
        end
        check(noisy ? "R10" : "R5", "stopped", stopped, 0);
        @(negedge clk); en = 0;
        @(negedge clk);
        check("R11", "count after en low", count, 0);
        check(i1 ? "R7" : "R11", "idle out1 level", out1, int'(i1));
        check("R11", "idle out2 level", out2, 0);
        idle_all();
    endtask

    task automatic t_fault();
        int n;
        logic [15:0] frozen;
        idle_all();
        reload = 16'd20; cmp1 = 16'd15; cmp2 = 16'd12; cmp3 = 16'd3;
        inv1 = 1; inv2 = 1;
        fire(n);
        repeat (5) @(negedge clk);
        fault1_en = 1; fault1_in = 1;
        repeat (2) @(posedge clk); #1;
        check("R8", "stopped before third edge", stopped, 0);
        @(posedge clk); #1;
        check("R8", "stopped at third edge", stopped, 1);
        check("R8", "out1 forced low", out1, 0);
        check("R8", "out2 forced low", out2, 0);
        frozen = count;
        @(negedge clk); fault1_in = 0; trig_in = 0;
        repeat (15) @(negedge clk);
        trig_in = 1;
        repeat (30) @(negedge clk);
        check("R9", "stop held through trigger", stopped, 1);
        check("R9", "count frozen", count, frozen);
        check("R9", "out1 low while held", out1, 0);
        inv1 = 0; inv2 = 0; trig_in = 0;
        stop_clr = 1; @(negedge clk); stop_clr = 0;
        check("R9", "stop cleared", stopped, 0);
        repeat (20) @(negedge clk);
        trig_in = 1;
        repeat (14) @(negedge clk);
        check("R9", "rearmed and running", int'(count != 0), 1);
        idle_all();
    endtask

    task automatic t_fault_mask();
        int n;
        idle_all();
        reload = 16'd20; cmp1 = 16'd15;
        fire(n);
        fault2_en = 0; fault2_in = 1;
        repeat (10) @(negedge clk);
        check("R8", "masked fault ignored", stopped, 0);
        fault2_en = 1;
        repeat (2) @(negedge clk);
        check("R8", "fault2 enabled stops", stopped, 1);
        fault2_in = 0; stop_clr = 1; @(negedge clk); stop_clr = 0;
        idle_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_delay(2'd0, 0);
        t_delay(2'd1, 2);
        t_delay(2'd2, 4);
        t_delay(2'd3, 8);
        t_glitch();
        t_trig_run();
        t_pwm(1'b0, 1'b0);
        t_pwm(1'b1, 1'b0);
        t_pwm(1'b0, 1'b1);
        t_fault();
        t_fault_mask();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule